// File: doc/BRIEF.md
# Register Transfer Decoder with One-Shot Prefix

This block turns a fixed 16-bit move-style instruction word into a register-to-register transfer. It splits the word into a source and a destination. The source is either an 8-bit literal carried in the word or a module/register pair that is read through an external register-file port. The destination is always a module/register pair. The block then fits the source value to the width of the destination. It clears every bit that the destination register does not implement, and it issues at most one write per instruction.

A small prefix register, held inside the block, widens both the addressing and the data path. Once it is written, its byte is visible for exactly one clock cycle and then reverts to zero. During that cycle the byte serves three purposes: it supplies the high byte when a narrow value lands in a wide register, it supplies the extra destination index bits needed to reach registers 8–31, and it supplies the extra source index bit needed to reach registers 16–31.

The register file is outside the block. For whichever addresses the block presents, it answers combinationally with data, a 16-bit width flag, a defined flag and an implemented-bit mask.

Top module: `rtd_xfer`

## Requirements
- R1: Instruction bit 15 selects the source kind: 0 means a literal in bits 7:0, and 1 means a register source. For a register source, `rd_mod` = bits 3:0, `rd_idx` = {prefix bit 2, bits 7:4}, and `rd_en` is high only when `instr_valid` is high and bit 15 = 1.
- R2: The destination is `wr_mod` = bits 11:8 and `wr_idx` = {prefix bits 4:3, bits 14:12}. Without a prefix, only indices 0–7 are reachable.
- R3: A transfer whose destination is module 4'hB, index 5'd3 loads the low byte of the source into the prefix and raises no `wr_en`. In the next cycle only, `pfx_active` is 1 and `pfx_byte` holds that byte. After that cycle both return to 0, whether or not an instruction follows.
- R4: When an 8-bit source (a register with `rd_is16`=0) goes to a 16-bit destination, `wr_data` = {prefix byte, source low byte}.
- R5: A 16-bit source going to an 8-bit destination transfers only its low byte. Equal widths copy every bit.
- R6: A literal source counts as an 8-bit source, so a 16-bit destination receives {prefix byte, literal}.
- R7: A register source with `rd_defined`=0 reads as {prefix byte, 8'h00} when its module's bit in `MOD_HAS8` is 1 (default 16'h0F0F), and as 16'h0000 otherwise.
- R8: A destination with `wr_defined`=0 produces no write (`wr_en`=0).
- R9: Source data is ANDed with `rd_mask`, and the written data is ANDed with `wr_mask`, so unimplemented bits are always 0.
- R10: While `rst_n` is low, `pfx_active`=0 and `pfx_byte`=0.
- R11: While `instr_valid` is low, `rd_en`=0 and `wr_en`=0, and the prefix is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| rd_en | output | 1 | Register source read this cycle |
| rd_mod | output | 4 | Source module |
| rd_idx | output | 5 | Source register index |
| rd_data | input | 16 | Source register contents |
| rd_is16 | input | 1 | Source register is 16 bits wide |
| rd_defined | input | 1 | Source register exists |
| rd_mask | input | 16 | Implemented bits of source register |
| wr_en | output | 1 | Destination write strobe |
| wr_mod | output | 4 | Destination module |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 16 | Data to write |
| wr_is16 | input | 1 | Destination register is 16 bits wide |
| wr_defined | input | 1 | Destination register exists |
| wr_mask | input | 16 | Implemented bits of destination register |
| pfx_active | output | 1 | Prefix loaded in the previous cycle |
| pfx_byte | output | 8 | Current prefix value (0 when inactive) |

## Verification
The assertions assume that the register file answers within the same cycle, so that `wr_is16`, `wr_defined` and `wr_mask` always describe the register named by the current `wr_mod`/`wr_idx`. They also assume that an 8-bit register's mask clears its upper byte. The bench models a register file with exactly these properties, and it derives the width, existence and mask purely from the module and index. Every stimulus word is applied between clock edges and held for a full cycle. Prefix-loading words are issued only where the expected prefix lifetime is being measured.

// File: rtl/rtd_pkg.sv
`timescale 1ns/1ps
package rtd_pkg;
  localparam int INSTR_W   = 16;
  localparam int DATA_W    = 16;
  localparam int BYTE_W    = DATA_W / 2;
  localparam int MOD_W     = 4;
  localparam int NMOD      = 1 << MOD_W;
  localparam int IDX_W     = 5;
  localparam int SRC_LO_W  = BYTE_W - MOD_W;
  localparam int DST_LO_W  = INSTR_W - 1 - BYTE_W - MOD_W;
  localparam int XSRC_W    = IDX_W - SRC_LO_W;
  localparam int XDST_W    = IDX_W - DST_LO_W;
  localparam int FMT_BIT   = INSTR_W - 1;
  localparam int DMOD_LO   = BYTE_W;
  localparam int DIDX_LO   = BYTE_W + MOD_W;
  localparam int PFX_XSRC_LO = 2;
  localparam int PFX_XDST_LO = 3;

  typedef enum logic {SRC_LIT = 1'b0, SRC_REG = 1'b1} src_kind_e;

  typedef struct packed {
    logic [DATA_W-1:0] val;
    logic              narrow;
  } src_word_t;

  // value read from a register slot that does not exist
  function automatic logic [DATA_W-1:0] absent_value(input logic has8,
                                                     input logic [BYTE_W-1:0] pfx);
    return has8 ? {pfx, {BYTE_W{1'b0}}} : {DATA_W{1'b0}};
  endfunction

  // fit a source word to the destination width, then drop unimplemented bits
  function automatic logic [DATA_W-1:0] fit_width(input src_word_t s,
                                                  input logic dst16,
                                                  input logic [BYTE_W-1:0] pfx,
                                                  input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] r;
    if (!dst16)
      r = {{(DATA_W-BYTE_W){1'b0}}, s.val[BYTE_W-1:0]};
    else if (s.narrow)
      r = {pfx, s.val[BYTE_W-1:0]};
    else
      r = s.val;
    return r & mask;
  endfunction
endpackage

// File: rtl/rtd_decode.sv
`timescale 1ns/1ps
module rtd_decode
  import rtd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [XSRC_W-1:0]  pfx_xsrc,
  input  logic [XDST_W-1:0]  pfx_xdst,
  output src_kind_e          kind,
  output logic [BYTE_W-1:0]  lit,
  output logic [MOD_W-1:0]   smod,
  output logic [IDX_W-1:0]   sidx,
  output logic [MOD_W-1:0]   dmod,
  output logic [IDX_W-1:0]   didx
);
  assign kind = src_kind_e'(instr[FMT_BIT]);
  assign lit  = instr[BYTE_W-1:0];
  assign smod = instr[MOD_W-1:0];
  assign sidx = {pfx_xsrc, instr[MOD_W +: SRC_LO_W]};
  assign dmod = instr[DMOD_LO +: MOD_W];
  assign didx = {pfx_xdst, instr[DIDX_LO +: DST_LO_W]};
endmodule

// File: rtl/rtd_prefix.sv
`timescale 1ns/1ps
module rtd_prefix
  import rtd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0] pfx_q,
  output logic              pfx_vld
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfx_q   <= '0;
      pfx_vld <= 1'b0;
    end else if (load) begin
      pfx_q   <= load_val;
      pfx_vld <= 1'b1;
    end else begin
      pfx_q   <= '0;
      pfx_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/rtd_widen.sv
`timescale 1ns/1ps
module rtd_widen
  import rtd_pkg::*;
(
  input  src_kind_e         kind,
  input  logic [BYTE_W-1:0] lit,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] rd_mask,
  input  logic              rd_is16,
  input  logic              rd_defined,
  input  logic              src_has8,
  input  logic [BYTE_W-1:0] pfx,
  input  logic              dst16,
  input  logic [DATA_W-1:0] dst_mask,
  output logic [BYTE_W-1:0] src_byte,
  output logic [DATA_W-1:0] xfer_data
);
  src_word_t src;

  always_comb begin
    if (kind == SRC_LIT) begin
      src.val    = {{(DATA_W-BYTE_W){1'b0}}, lit};
      src.narrow = 1'b1;
    end else if (rd_defined) begin
      src.val    = rd_data & rd_mask;
      src.narrow = !rd_is16;
    end else begin
      src.val    = absent_value(src_has8, pfx);
      src.narrow = 1'b0;
    end
  end

  assign src_byte  = src.val[BYTE_W-1:0];
  assign xfer_data = fit_width(src, dst16, pfx, dst_mask);
endmodule

// File: rtl/rtd_xfer.sv
`timescale 1ns/1ps
module rtd_xfer
  import rtd_pkg::*;
#(
  parameter logic [MOD_W-1:0] PFX_MOD  = 4'hB,
  parameter logic [IDX_W-1:0] PFX_IDX  = 5'd3,
  parameter logic [NMOD-1:0]  MOD_HAS8 = 16'h0F0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic               rd_en,
  output logic [MOD_W-1:0]   rd_mod,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               rd_is16,
  input  logic               rd_defined,
  input  logic [DATA_W-1:0]  rd_mask,
  output logic               wr_en,
  output logic [MOD_W-1:0]   wr_mod,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [DATA_W-1:0]  wr_data,
  input  logic               wr_is16,
  input  logic               wr_defined,
  input  logic [DATA_W-1:0]  wr_mask,
  output logic               pfx_active,
  output logic [BYTE_W-1:0]  pfx_byte
);
  src_kind_e         kind;
  logic [BYTE_W-1:0] lit;
  logic [BYTE_W-1:0] pfx_q;
  logic              pfx_vld;
  logic [BYTE_W-1:0] src_byte;
  logic              dst_is_pfx;
  logic              pfx_load;
  logic              src_has8;

  rtd_decode u_decode (
    .instr    (instr),
    .pfx_xsrc (pfx_q[PFX_XSRC_LO +: XSRC_W]),
    .pfx_xdst (pfx_q[PFX_XDST_LO +: XDST_W]),
    .kind     (kind),
    .lit      (lit),
    .smod     (rd_mod),
    .sidx     (rd_idx),
    .dmod     (wr_mod),
    .didx     (wr_idx)
  );

  assign src_has8 = MOD_HAS8[rd_mod];

  rtd_widen u_widen (
    .kind       (kind),
    .lit        (lit),
    .rd_data    (rd_data),
    .rd_mask    (rd_mask),
    .rd_is16    (rd_is16),
    .rd_defined (rd_defined),
    .src_has8   (src_has8),
    .pfx        (pfx_q),
    .dst16      (wr_is16),
    .dst_mask   (wr_mask),
    .src_byte   (src_byte),
    .xfer_data  (wr_data)
  );

  assign dst_is_pfx = (wr_mod == PFX_MOD) && (wr_idx == PFX_IDX);
  assign pfx_load   = instr_valid && dst_is_pfx;
  assign wr_en      = instr_valid && wr_defined && !dst_is_pfx;
  assign rd_en      = instr_valid && (kind == SRC_REG);

  rtd_prefix u_prefix (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pfx_load),
    .load_val (src_byte),
    .pfx_q    (pfx_q),
    .pfx_vld  (pfx_vld)
  );

  assign pfx_active = pfx_vld;
  assign pfx_byte   = pfx_q;
endmodule

// File: rtl/rtd_xfer_chk.sv
`timescale 1ns/1ps
module rtd_xfer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic        src_fmt,
  input logic [3:0]  dst_mod_field,
  input logic        rd_en,
  input logic        wr_en,
  input logic [3:0]  wr_mod,
  input logic [15:0] wr_data,
  input logic [15:0] wr_mask,
  input logic        wr_is16,
  input logic        wr_defined,
  input logic        pfx_load,
  input logic        pfx_active,
  input logic [7:0]  pfx_byte
);
  assert_rd_needs_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (instr_valid && src_fmt));

  assert_dst_module_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_mod == dst_mod_field));

  assert_pfx_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_load |=> pfx_active);

  assert_pfx_oneshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_load |=> (!pfx_active && pfx_byte == 8'h00));

  assert_pfx_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_load |-> !wr_en);

  assert_lit_high_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_is16 && !src_fmt) |-> (wr_data[15:8] == (pfx_byte & wr_mask[15:8])));

  assert_undef_dst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_defined |-> !wr_en);

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~wr_mask) == 16'h0000));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!wr_en && !rd_en && !pfx_load));
endmodule

bind rtd_xfer rtd_xfer_chk u_rtd_xfer_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .src_fmt       (instr[15]),
  .dst_mod_field (instr[11:8]),
  .rd_en         (rd_en),
  .wr_en         (wr_en),
  .wr_mod        (wr_mod),
  .wr_data       (wr_data),
  .wr_mask       (wr_mask),
  .wr_is16       (wr_is16),
  .wr_defined    (wr_defined),
  .pfx_load      (pfx_load),
  .pfx_active    (pfx_active),
  .pfx_byte      (pfx_byte)
);

// File: tb/test_rtd_xfer.sv
`timescale 1ns/1ps
module test_rtd_xfer;
  localparam logic [15:0] HAS8 = 16'h0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic        rd_en, wr_en, pfx_active;
  logic [3:0]  rd_mod, wr_mod;
  logic [4:0]  rd_idx, wr_idx;
  logic [15:0] rd_data, rd_mask, wr_data, wr_mask;
  logic        rd_is16, rd_defined, wr_is16, wr_defined;
  logic [7:0]  pfx_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  rtd_xfer i_rtd_xfer (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .rd_en(rd_en), .rd_mod(rd_mod), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_is16(rd_is16), .rd_defined(rd_defined), .rd_mask(rd_mask),
    .wr_en(wr_en), .wr_mod(wr_mod), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_is16(wr_is16), .wr_defined(wr_defined), .wr_mask(wr_mask),
    .pfx_active(pfx_active), .pfx_byte(pfx_byte)
  );

  // register-file model: properties derive from module and index alone
  function automatic bit m_has8(input logic [3:0] m);
    return HAS8[m];
  endfunction
  function automatic bit m_is16(input logic [3:0] m, input logic [4:0] i);
    return !m_has8(m) || i[0];
  endfunction
  function automatic bit m_def(input logic [4:0] i);
    return i[1:0] != 2'd3;
  endfunction
  function automatic logic [15:0] m_mask(input logic [3:0] m, input logic [4:0] i);
    if (m_is16(m, i)) return i[1] ? 16'h0FFF : 16'hFFFF;
    return i[1] ? 16'h007F : 16'h00FF;
  endfunction
  function automatic logic [15:0] m_val(input logic [3:0] m, input logic [4:0] i);
    return 16'h9C35 ^ (16'(m) * 16'h1111) ^ (16'(i) * 16'h0203);
  endfunction

  always_comb begin
    rd_data    = m_val(rd_mod, rd_idx);
    rd_is16    = m_is16(rd_mod, rd_idx);
    rd_defined = m_def(rd_idx);
    rd_mask    = m_mask(rd_mod, rd_idx);
    wr_is16    = m_is16(wr_mod, wr_idx);
    wr_defined = m_def(wr_idx);
    wr_mask    = m_mask(wr_mod, wr_idx);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic v);
    @(negedge clk);
    instr = w;
    instr_valid = v;
    #1;
  endtask

  // expected transfer computed arithmetically from the requirements
  task automatic expect_xfer(input logic [15:0] w, input int p);
    int sval, edat, mask;
    bit s8, eld, ewr;
    int dm, di, sm, si;
    string tag;
    sm = w[3:0];
    si = ((p >> 2) & 1) * 16 + w[7:4];
    dm = w[11:8];
    di = ((p >> 3) & 3) * 8 + w[14:12];
    if (!w[15]) begin
      sval = w[7:0]; s8 = 1; tag = "R6";
    end else if (m_def(5'(si))) begin
      sval = m_val(4'(sm), 5'(si)) & m_mask(4'(sm), 5'(si));
      s8 = !m_is16(4'(sm), 5'(si));
      tag = s8 ? "R4" : "R5";
    end else begin
      sval = m_has8(4'(sm)) ? p * 256 : 0; s8 = 0; tag = "R7";
    end
    eld = (dm == 11) && (di == 3);
    ewr = !eld && m_def(5'(di));
    if (!eld && !m_def(5'(di))) tag = "R8";
    mask = m_mask(4'(dm), 5'(di));
    if (m_is16(4'(dm), 5'(di)))
      edat = (s8 ? (p * 256 + sval % 256) : sval) & mask;
    else
      edat = (sval % 256) & mask;
    if (eld) tag = "R3";
    chk(rd_en == w[15], "R1 rd_en", rd_en, w[15]);
    if (w[15]) begin
      chk(rd_mod == sm && rd_idx == si, "R1 rd_addr", {rd_mod, rd_idx}, sm * 32 + si);
    end
    chk(wr_en == ewr, {tag, " wr_en"}, wr_en, ewr);
    if (ewr) begin
      chk(wr_mod == dm && wr_idx == di, "R2 wr_addr", {wr_mod, wr_idx}, dm * 32 + di);
      chk(wr_data == 16'(edat), {tag, " wr_data"}, wr_data, edat);
      chk((wr_data & ~wr_mask) == 16'h0, "R9 masked bits", wr_data & ~wr_mask, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w2;
    repeat (3) @(negedge clk);
    #1;
    chk(pfx_active == 1'b0, "R10 pfx_active", pfx_active, 0);
    chk(pfx_byte == 8'h00, "R10 pfx_byte", pfx_byte, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // register sources, no prefix
    for (int sm = 0; sm < 16; sm++)
      for (int si = 0; si < 16; si++)
        for (int dm = 0; dm < 16; dm++)
          for (int di = 0; di < 8; di++) begin
            if (dm == 11 && di == 3) continue;
            step({1'b1, 3'(di), 4'(dm), 4'(si), 4'(sm)}, 1'b1);
            expect_xfer(instr, 0);
          end

    // literal sources, no prefix
    for (int v = 0; v < 256; v++)
      for (int dm = 0; dm < 16; dm++)
        for (int di = 0; di < 8; di++) begin
          if (dm == 11 && di == 3) continue;
          step({1'b0, 3'(di), 4'(dm), 8'(v)}, 1'b1);
          expect_xfer(instr, 0);
        end

    // every prefix value, followed by a transfer that uses it, then expiry
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pb;
      pb = 8'(p);
      step({1'b0, 3'd3, 4'hB, pb}, 1'b1);
      chk(wr_en == 1'b0, "R3 load has no write", wr_en, 0);
      w2 = {pb[0], pb[7:5], pb[3:0] ^ 4'h5, pb[3:0], pb[7:4]};
      if (w2[11:8] == 4'hB && pb[4:3] == 2'b00 && w2[14:12] == 3'd3) w2[12] = 1'b0;
      step(w2, 1'b1);
      chk(pfx_active == 1'b1, "R3 active", pfx_active, 1);
      chk(pfx_byte == pb, "R3 byte", pfx_byte, p);
      expect_xfer(w2, p);
      step(16'h0000, 1'b0);
      chk(pfx_active == 1'b0 && pfx_byte == 8'h00, "R3 expiry", {pfx_active, pfx_byte}, 0);
      chk(wr_en == 1'b0 && rd_en == 1'b0, "R11 idle", {wr_en, rd_en}, 0);
    end

    // prefix survives an idle cycle for exactly one cycle
    step({1'b0, 3'd3, 4'hB, 8'h5A}, 1'b1);
    step({1'b1, 3'd0, 4'h2, 4'h1, 4'h0}, 1'b0);
    chk(pfx_active && pfx_byte == 8'h5A, "R3 hold over idle", pfx_byte, 8'h5A);
    chk(!wr_en && !rd_en, "R11 idle with word present", {wr_en, rd_en}, 0);
    step(16'h0000, 1'b0);
    chk(!pfx_active && pfx_byte == 8'h00, "R3 gone after one cycle", pfx_byte, 0);

    // prefix write with valid low is not taken
    step({1'b0, 3'd3, 4'hB, 8'hC3}, 1'b0);
    step(16'h0000, 1'b0);
    chk(!pfx_active && pfx_byte == 8'h00, "R11 no load when invalid", pfx_byte, 0);

    // undefined source in an 8-bit-capable module with prefix 8'hE4 (src bit4 set)
    step({1'b0, 3'd3, 4'hB, 8'hE4}, 1'b1);
    step({1'b1, 3'd1, 4'h3, 4'h3, 4'h0}, 1'b1);
    expect_xfer(instr, 8'hE4);
    step(16'h0000, 1'b0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule